// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a target on a two-wire serial bus that follows the SMBus framing. It gives a host controller read and write access to a small bank of configuration bytes inside the chip. The block runs on the system clock and oversamples the bus clock and data lines. It drives the data line only by asserting an open-drain enable that pulls the line low.

The command byte selects the kind of access. When its top bit is set, the lower seven bits give the offset of one byte to write or read. When its top bit is clear, the transfer is a block transfer. A block transfer always begins at offset zero and walks upward through the bank. A block write carries a byte-count byte before its data. A block read returns a byte count first and then the registers in ascending order. The host may close either kind of transfer after any whole byte. A start or stop condition in the middle of a byte abandons the transaction, and nothing is written from the partial byte. The whole bank is visible to the rest of the chip as one flat output vector.

Top module: `smbt_cfg_target`

## Requirements
- R1: The target answers only the 7-bit address 69h. The address byte is D2h for a write and D3h for a read. Any other address byte is not acknowledged, and every following byte is ignored until the next start condition.
- R2: A command byte with bit 7 = 1 selects a single-byte access at the offset in bits 6:0. A byte write stores exactly one data byte at that offset. A second data byte in the same transaction is not acknowledged and is not stored.
- R3: A command byte with bit 7 = 0 selects a block write. The next byte is a count N. Up to N data bytes are then stored at offsets 0, 1, 2 and upward. Any data byte beyond N is not acknowledged and is not stored.
- R4: A byte read runs as follows: start, D2h, a command with bit 7 = 1, repeated start, D3h. The target then returns the register at the commanded offset, most significant bit first.
- R5: A block read runs as follows: start, D2h, a command with bit 7 = 0, repeated start, D3h. The target first returns the count 8. It then returns the registers from offset 0 upward for as long as the host acknowledges. After the host does not acknowledge a byte, the target leaves the data line released.
- R6: Offsets 8 and above read as 00h, and writes to them change nothing.
- R7: The host may send a stop after any complete data byte. Every data byte completed before that stop is kept.
- R8: A start or stop condition before the 8th bit of a byte ends the transaction, and that partial byte is never written.
- R9: After reset, register i holds 5Ah + 11h*i (5A, 6B, 7C, 8D, 9E, AF, C0, D1). Register i appears on cfg_q bits [8i+7:8i].
- R10: The target acknowledges its own address, the command byte, the count byte and every stored data byte by pulling the data line low during the 9th clock. The data-line enable changes only while the bus clock is low, except when the host sends a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| cfg_q | output | 64 | Contents of the register bank, register i at bits [8i+7:8i] |

## Verification
Both bus lines pass through two synchronizer stages and one edge register. A reaction to a clock edge therefore shows on sda_oe about four system cycles after that edge. The bench holds each bus clock phase for eight cycles. It changes the data line two cycles after a falling clock edge, and it samples acknowledges and read bits at the end of a high phase, when sda_oe has long settled. A register write appears on cfg_q about four cycles after the falling edge that ends its 8th bit. The bench compares cfg_q only after the closing stop has been held for a full phase, so each register update is seen at a fixed point.

// File: rtl/smbt_pkg.sv
// Package with the shared types of the two-wire configuration target.
// Assumes: the engine module uses these types for its state and phase registers.
package smbt_pkg;

    // Bit-level state of the target
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_RX,     // shifting in a byte from the host
        ST_ACK,    // pulling the data line low in the 9th clock
        ST_TX,     // shifting a byte out to the host
        ST_MACK,   // released, waiting for the host acknowledge
        ST_SKIP    // released until the next start or stop
    } st_e;

    // Meaning of the byte now being received
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } ph_e;

endpackage

// File: rtl/smbt_sync.sv
// Synchronizes the bus clock and data lines into the system clock domain and
// derives clock edges and start/stop conditions from them.
// Assumes: the bus clock phases are several system clocks long; the idle bus is high.
module smbt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
            for (int k = 1; k < STAGES; k++) begin
                scl_pipe[k] <= scl_pipe[k-1];
                sda_pipe[k] <= sda_pipe[k-1];
            end
            scl_d <= scl_pipe[STAGES-1];
            sda_d <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Edge and condition decode
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({scl_rise, scl_fall, start_ev, stop_ev}) <= 1); // R8

endmodule

// File: rtl/smbt_regbank.sv
// Configuration register bank with reset defaults, one write port and one read port.
// Assumes: offsets at or beyond DEPTH are not backed, so they read as zero and
// writes to them are dropped.
module smbt_regbank #(
    parameter int         DEPTH = 8,
    parameter logic [7:0] SEED  = 8'h5A,
    parameter logic [7:0] STEP  = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [6:0]         wr_off,
    input  logic [7:0]         wr_data,
    input  logic [6:0]         rd_off,
    output logic [7:0]         rd_data,
    output logic [8*DEPTH-1:0] cfg_q
);
    logic [7:0] regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        localparam logic [7:0] INIT = SEED + 8'(i * int'(STEP));
        // One storage byte: load its default at reset, else take a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= INIT;
            else if (wr_en && wr_off == 7'(i))
                regs[i] <= wr_data;
        end
        assign cfg_q[8*i +: 8] = regs[i];
    end

    // Read mux that returns zero for unbacked offsets
    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < DEPTH; k++)
            if (rd_off == 7'(k)) rd_data = regs[k];
    end

    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_off) >= DEPTH) |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/smbt_engine.sv
// Protocol engine of the two-wire target. It decodes the address, command,
// count and data bytes, drives acknowledges and read data, and generates the
// register-bank accesses.
// Assumes: the input events come from smbt_sync, at most one per cycle.
module smbt_engine
    import smbt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         DEPTH    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [6:0] wr_off,
    output logic [7:0] wr_data,
    output logic [6:0] rd_off,
    input  logic [7:0] rd_data
);
    localparam logic [7:0] BLK_COUNT = 8'(DEPTH);

    st_e        st;
    ph_e        ph;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       rd_mode;
    logic       blk;
    logic [6:0] cmd_off;
    logic [6:0] ptr;
    logic [7:0] remain;
    logic       cnt_pend;
    logic       mnack;
    logic       byte_done;

    // A received byte is complete at the falling edge after its 8th bit
    assign byte_done = (st == ST_RX) && scl_fall && (bit_cnt == 4'd8);

    // Write strobe to the bank for an accepted data byte
    always_comb begin
        wr_en   = byte_done && (ph == PH_DATA) && (remain != 8'd0);
        wr_off  = ptr;
        wr_data = shreg;
        rd_off  = ptr;
    end

    // Data line drive: a low acknowledge, or a zero bit during transmit
    always_comb begin
        sda_oe = (st == ST_ACK) || ((st == ST_TX) && !shreg[7]);
    end

    // Main state machine, advanced by bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ph       <= PH_ADDR;
            bit_cnt  <= 4'd0;
            shreg    <= 8'h00;
            rd_mode  <= 1'b0;
            blk      <= 1'b0;
            cmd_off  <= 7'd0;
            ptr      <= 7'd0;
            remain   <= 8'd0;
            cnt_pend <= 1'b0;
            mnack    <= 1'b0;
        end else if (start_ev) begin
            st      <= ST_RX;
            ph      <= PH_ADDR;
            bit_cnt <= 4'd0;
            rd_mode <= 1'b0;
        end else if (stop_ev) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        case (ph)
                            PH_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    st      <= ST_ACK;
                                    rd_mode <= shreg[0];
                                    if (shreg[0]) begin
                                        ptr      <= blk ? 7'd0 : cmd_off;
                                        cnt_pend <= blk;
                                    end else begin
                                        ph <= PH_CMD;
                                    end
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                            PH_CMD: begin
                                blk     <= ~shreg[7];
                                cmd_off <= shreg[7] ? shreg[6:0] : 7'd0;
                                ptr     <= shreg[7] ? shreg[6:0] : 7'd0;
                                remain  <= shreg[7] ? 8'd1 : 8'd0;
                                ph      <= shreg[7] ? PH_DATA : PH_COUNT;
                                st      <= ST_ACK;
                            end
                            PH_COUNT: begin
                                remain <= shreg;
                                ph     <= PH_DATA;
                                st     <= ST_ACK;
                            end
                            default: begin
                                if (remain != 8'd0) begin
                                    ptr    <= ptr + 7'd1;
                                    remain <= remain - 8'd1;
                                    st     <= ST_ACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= 4'd0;
                        if (rd_mode) begin
                            st <= ST_TX;
                            if (cnt_pend) begin
                                shreg    <= BLK_COUNT;
                                cnt_pend <= 1'b0;
                            end else begin
                                shreg <= rd_data;
                                ptr   <= ptr + 7'd1;
                            end
                        end else begin
                            st <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            st <= ST_MACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mnack <= sda_s;
                    end else if (scl_fall) begin
                        bit_cnt <= 4'd0;
                        if (mnack) begin
                            st <= ST_SKIP;
                        end else begin
                            st    <= ST_TX;
                            shreg <= rd_data;
                            ptr   <= ptr + 7'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_QUIET_WHEN_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe); // R1
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe)); // R10
    AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (remain == $past(remain) - 8'd1)); // R3
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + 7'd1)); // R2
    AST_NO_WRITE_ON_CONDITION: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |-> !wr_en); // R8
    AST_RELEASE_FOR_HOST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK) |-> !sda_oe); // R5

endmodule

// File: rtl/smbt_cfg_target.sv
// Top of the two-wire configuration target: input synchronizer, protocol
// engine and register bank.
// Assumes: the SDA pad is open drain, so sda_oe high pulls the line low.
module smbt_cfg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         DEPTH       = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DFLT_SEED   = 8'h5A,
    parameter logic [7:0] DFLT_STEP   = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [8*DEPTH-1:0] cfg_q
);
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_ev;
    logic       stop_ev;
    logic       wr_en;
    logic [6:0] wr_off;
    logic [7:0] wr_data;
    logic [6:0] rd_off;
    logic [7:0] rd_data;

    smbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smbt_engine #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_off   (wr_off),
        .wr_data  (wr_data),
        .rd_off   (rd_off),
        .rd_data  (rd_data)
    );

    smbt_regbank #(.DEPTH(DEPTH), .SEED(DFLT_SEED), .STEP(DFLT_STEP)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_off  (wr_off),
        .wr_data (wr_data),
        .rd_off  (rd_off),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

endmodule

// File: tb/sim_smbt_cfg_target.sv
`timescale 1ns/1ps
module sim_smbt_cfg_target;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic [63:0] cfg_q;
    logic [7:0]  mdl [8];
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    smbt_cfg_target u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .cfg_q  (cfg_q)
    );

    // Byte write vectors: {offset, data}
    localparam logic [15:0] VEC [5] = '{16'h00_11, 16'h03_C4, 16'h07_FF, 16'h05_00, 16'h02_A5};

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int k = 0; k < 8; k++) f[8*k +: 8] = mdl[k];
        return f;
    endfunction

    task automatic set_defaults();
        for (int k = 0; k < 8; k++) mdl[k] = 8'h5A + 8'(k * 17);
    endtask

    task automatic b_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(W);
        m_sda = 1'b0; tick(W);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic b_rstart();
        m_sda = 1'b1; tick(W);
        m_scl = 1'b1; tick(W);
        m_sda = 1'b0; tick(W);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic b_stop();
        m_sda = 1'b0; tick(W);
        m_scl = 1'b1; tick(W);
        m_sda = 1'b1; tick(W);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(W);
            m_scl = 1'b1; tick(W);
            m_scl = 1'b0; tick(2);
        end
    endtask

    // Send a byte; acked = 1 when the target pulled the line low in the 9th clock
    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(W);
        m_scl = 1'b1; tick(W);
        acked = ~sda_bus;
        m_scl = 1'b0; tick(2);
    endtask

    // Receive a byte; nack = 1 ends the read
    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1; tick(W);
        for (int i = 0; i < 8; i++) begin
            m_scl = 1'b1; tick(W);
            b = {b[6:0], sda_bus};
            m_scl = 1'b0; tick(W);
        end
        m_sda = nack; tick(W);
        m_scl = 1'b1; tick(W);
        m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    task automatic byte_wr(input logic [6:0] off, input logic [7:0] d, output logic acked);
        logic a0, a1;
        b_start();
        send_byte(8'hD2, a0);
        send_byte({1'b1, off}, a1);
        send_byte(d, acked);
        b_stop();
        acked = acked & a0 & a1;
    endtask

    task automatic byte_rd(input logic [6:0] off, output logic [7:0] d);
        logic a;
        b_start();
        send_byte(8'hD2, a);
        send_byte({1'b1, off}, a);
        b_rstart();
        send_byte(8'hD3, a);
        recv_byte(1'b1, d);
        b_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] d;
        set_defaults();
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R9 reset defaults", cfg_q, model_flat());
        chk("R10 line released after reset", {63'd0, sda_oe}, 64'd0);

        // Table of byte writes, each read back (R2, R4, R10)
        for (int v = 0; v < 5; v++) begin
            byte_wr(VEC[v][14:8], VEC[v][7:0], a);
            mdl[VEC[v][10:8]] = VEC[v][7:0];
            chk("R10 byte write acked", {63'd0, a}, 64'd1);
            chk("R2 byte write stored", cfg_q, model_flat());
            byte_rd(VEC[v][14:8], d);
            chk("R4 byte read value", {56'd0, d}, {56'd0, VEC[v][7:0]});
        end

        // Offsets beyond the bank (R6)
        byte_wr(7'd9, 8'h33, a);
        chk("R6 write beyond bank ignored", cfg_q, model_flat());
        byte_rd(7'h7F, d);
        chk("R6 read beyond bank is zero", {56'd0, d}, 64'd0);

        // Foreign address (R1)
        b_start();
        send_byte(8'hA0, a);
        chk("R1 foreign address not acked", {63'd0, a}, 64'd0);
        send_byte(8'h80, a);
        send_byte(8'h99, a);
        b_stop();
        chk("R1 foreign transaction ignored", cfg_q, model_flat());

        // Block write of three bytes, a fourth is refused (R3)
        b_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        chk("R3 block command acked", {63'd0, a}, 64'd1);
        send_byte(8'h03, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_byte(8'h03, a);
        chk("R3 last counted byte acked", {63'd0, a}, 64'd1);
        send_byte(8'h04, a);
        chk("R3 byte beyond count not acked", {63'd0, a}, 64'd0);
        b_stop();
        mdl[0] = 8'h01; mdl[1] = 8'h02; mdl[2] = 8'h03;
        chk("R3 block write contents", cfg_q, model_flat());

        // Full block read (R5)
        b_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        b_rstart();
        send_byte(8'hD3, a);
        recv_byte(1'b0, d);
        chk("R5 block read count", {56'd0, d}, 64'd8);
        for (int k = 0; k < 8; k++) begin
            recv_byte(k == 7, d);
            chk("R5 block read data", {56'd0, d}, {56'd0, mdl[k]});
        end
        chk("R5 released after host nack", {63'd0, sda_oe}, 64'd0);
        b_stop();

        // Short block read ended by host nack (R5)
        b_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        b_rstart();
        send_byte(8'hD3, a);
        recv_byte(1'b0, d);
        recv_byte(1'b0, d);
        recv_byte(1'b1, d);
        chk("R5 short read second byte", {56'd0, d}, {56'd0, mdl[1]});
        m_sda = 1'b1; tick(W); m_scl = 1'b1; tick(W);
        chk("R5 no drive after nack", {63'd0, sda_bus}, 64'd1);
        m_scl = 1'b0; tick(2);
        b_stop();

        // Block write stopped after two of five bytes (R7)
        b_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h05, a);
        send_byte(8'hEE, a);
        send_byte(8'hDD, a);
        b_stop();
        mdl[0] = 8'hEE; mdl[1] = 8'hDD;
        chk("R7 bytes before stop kept", cfg_q, model_flat());

        // Stop in the middle of a data byte (R8)
        b_start();
        send_byte(8'hD2, a);
        send_byte(8'h84, a);
        send_bits(8'h77, 4);
        b_stop();
        chk("R8 partial byte before stop not written", cfg_q, model_flat());

        // Start in the middle of a data byte (R8)
        b_start();
        send_byte(8'hD2, a);
        send_byte(8'h86, a);
        send_bits(8'h12, 3);
        b_rstart();
        b_stop();
        chk("R8 partial byte before start not written", cfg_q, model_flat());

        // Second data byte of a byte write refused (R2)
        b_start();
        send_byte(8'hD2, a);
        send_byte(8'h81, a);
        send_byte(8'h5C, a);
        chk("R2 first data byte acked", {63'd0, a}, 64'd1);
        send_byte(8'h77, a);
        chk("R2 second data byte not acked", {63'd0, a}, 64'd0);
        b_stop();
        mdl[1] = 8'h5C;
        chk("R2 only one byte stored", cfg_q, model_flat());

        // Reset restores defaults (R9)
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick(3);
        set_defaults();
        chk("R9 defaults after second reset", cfg_q, model_flat());

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule